// File: doc/BRIEF.md
# Readout Fragment Event Builder

The block collects readout data from up to eight tower links and merges it into one fragment per trigger event. Each link sends 16-bit words in fragments. A fragment opens with a header word whose low twelve bits carry the event number, and a last flag marks its final word. Every link writes into its own 64-entry FIFO. The FIFOs keep accepting words while the merger is busy with another link or another event.

A trigger event is presented on a small request port as an event number plus a mask of the links that take part. The merger accepts one request at a time and writes a header word. It then walks the enabled links from the lowest index upward and drains exactly one fragment from each, packing pairs of 16-bit words into 32-bit output words. It closes the fragment with a trailer word that gives the word count and a mismatch flag. The output is a 32-bit stream with a valid/ready handshake and a last marker.

Top module: `frag_event_builder`

## Requirements
- R1: Each link has its own 64-word FIFO. Its `in_ready` goes low only once the FIFO is full, and every word accepted while `in_ready` is high later appears in the output unchanged.
- R2: The first output word of every fragment is a header. Bits 31:28 are 0xB. Bits 23:16 are the latched link mask, with bit i standing for link i. Bits 11:0 are the requested event number. All other bits are zero.
- R3: Links whose mask bit is set are drained in ascending index order, one complete fragment each, ending at the word flagged by `in_last`. A link whose mask bit is clear is not read, and its buffered fragment stays queued for a later event.
- R4: The copied 16-bit words form one continuous stream across all links. Each pair fills one output word, with the earlier word in bits 31:16. If the total count is odd, the final data word carries 0x0000 in bits 15:0.
- R5: The last output word of every fragment is a trailer, marked by `out_last`. Bits 31:28 are 0xE. Bit 27 is the error flag. Bits 15:0 hold the number of 16-bit words copied. All other bits are zero. A request with an empty mask gives just a header and a trailer.
- R6: The error flag is set when bits 11:0 of the first word of any drained link fragment differ from the requested event number. That fragment is still copied in full.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R8: `ev_ready` is high only while the merger is idle. It drops in the cycle after a request is accepted.
- R9: During and right after reset, `out_valid` is low, every `in_ready` is high and `ev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_LINKS | Per-link word valid |
| in_data | input | 16*N_LINKS | Per-link word, link i in bits 16i+15:16i |
| in_last | input | N_LINKS | Per-link end-of-fragment flag |
| in_ready | output | N_LINKS | Per-link FIFO not full |
| ev_valid | input | 1 | Event request valid |
| ev_id | input | 12 | Requested event number |
| link_en | input | N_LINKS | Links taking part in the request |
| ev_ready | output | 1 | Request accepted when high with ev_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Output word is the trailer |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The main sweep issues one request for every one of the 256 link masks. Fragment lengths of one to four words are staggered per link, so the sweep covers the empty mask, single links, full masks, odd and even totals and pairs that straddle a link boundary. It also alternates between constant and pseudo-random output backpressure, which separates packing errors from handshake errors. Three directed cases cover the rest. One sets a mismatched event number on a single link, which separates error flagging from dropping the fragment. One leaves a buffered fragment on a disabled link and shows that it is taken later rather than skipped. One sends a 70-word fragment into the 64-word FIFO, which shows that backpressure does not lose data.

// File: rtl/feb_pkg.sv
package feb_pkg;

    localparam int MAX_LINKS = 8;
    localparam int IDX_W     = 4;
    localparam int EVID_W    = 12;
    localparam int CNT_W     = 16;

    localparam logic [3:0] HDR_TAG = 4'hB;
    localparam logic [3:0] TRL_TAG = 4'hE;

    typedef struct packed {
        logic        last;
        logic [15:0] data;
    } lword_t;

    typedef struct packed {
        logic        last;
        logic [31:0] data;
    } oword_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_SCAN,
        ST_COPY,
        ST_PAD,
        ST_TRL
    } mstate_t;

    // Lowest set mask bit at or above start; MAX_LINKS when there is none.
    function automatic logic [IDX_W-1:0] next_link(input logic [MAX_LINKS-1:0] mask,
                                                   input logic [IDX_W-1:0] start);
        logic [IDX_W-1:0] r;
        r = IDX_W'(MAX_LINKS);
        for (int i = MAX_LINKS - 1; i >= 0; i--) begin
            if (mask[i] && (IDX_W'(i) >= start)) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [31:0] make_header(input logic [MAX_LINKS-1:0] mask,
                                                input logic [EVID_W-1:0] id);
        return {HDR_TAG, 4'h0, mask, 4'h0, id};
    endfunction

    function automatic logic [31:0] make_trailer(input logic err,
                                                 input logic [CNT_W-1:0] cnt);
        return {TRL_TAG, err, 11'h000, cnt};
    endfunction

endpackage

// File: rtl/feb_link_fifo.sv
module feb_link_fifo
    import feb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_valid,
    input  lword_t wr_word,
    output logic   wr_ready,
    input  logic   rd_pop,
    output lword_t rd_word,
    output logic   rd_avail
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    lword_t         mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_wr, do_rd;

    assign wr_ready = (count != CW'(DEPTH));
    assign rd_avail = (count != '0);
    assign do_wr    = wr_valid && wr_ready;
    assign do_rd    = rd_pop && rd_avail;
    assign rd_word  = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/feb_merge_ctrl.sv
module feb_merge_ctrl
    import feb_pkg::*;
#(
    parameter int N_LINKS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_valid,
    input  logic [EVID_W-1:0]  ev_id,
    input  logic [N_LINKS-1:0] link_en,
    output logic               ev_ready,
    output logic [IDX_W-1:0]   sel_idx,
    input  logic               sel_avail,
    input  lword_t             sel_word,
    output logic               sel_pop,
    input  logic               can_push,
    output logic               push,
    output oword_t             push_word
);
    mstate_t                state;
    logic [EVID_W-1:0]      ev_id_q;
    logic [MAX_LINKS-1:0]   mask_q;
    logic [IDX_W-1:0]       idx_q;
    logic [IDX_W-1:0]       nxt;
    logic [15:0]            hi_q;
    logic                   half_q;
    logic                   first_q;
    logic                   err_q;
    logic [CNT_W-1:0]       cnt_q;

    assign nxt      = next_link(mask_q, idx_q);
    assign sel_idx  = idx_q;
    assign ev_ready = (state == ST_IDLE);
    assign sel_pop  = (state == ST_COPY) && sel_avail && (!half_q || can_push);

    always_comb begin
        push      = 1'b0;
        push_word = '0;
        case (state)
            ST_HDR: begin
                push           = can_push;
                push_word.data = make_header(mask_q, ev_id_q);
            end
            ST_COPY: begin
                push           = sel_pop && half_q;
                push_word.data = {hi_q, sel_word.data};
            end
            ST_PAD: begin
                push           = can_push;
                push_word.data = {hi_q, 16'h0000};
            end
            ST_TRL: begin
                push           = can_push;
                push_word.last = 1'b1;
                push_word.data = make_trailer(err_q, cnt_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ev_id_q <= '0;
            mask_q  <= '0;
            idx_q   <= '0;
            hi_q    <= '0;
            half_q  <= 1'b0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ev_valid) begin
                        ev_id_q <= ev_id;
                        mask_q  <= MAX_LINKS'(link_en);
                        state   <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (can_push) begin
                        idx_q   <= '0;
                        first_q <= 1'b1;
                        half_q  <= 1'b0;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                        state   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (nxt == IDX_W'(MAX_LINKS)) begin
                        state <= half_q ? ST_PAD : ST_TRL;
                    end else begin
                        idx_q <= nxt;
                        state <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (sel_pop) begin
                        cnt_q   <= cnt_q + 1'b1;
                        first_q <= 1'b0;
                        if (first_q && (sel_word.data[EVID_W-1:0] != ev_id_q)) err_q <= 1'b1;
                        if (half_q) begin
                            half_q <= 1'b0;
                        end else begin
                            hi_q   <= sel_word.data;
                            half_q <= 1'b1;
                        end
                        if (sel_word.last) begin
                            idx_q   <= idx_q + 1'b1;
                            first_q <= 1'b1;
                            state   <= ST_SCAN;
                        end
                    end
                end
                ST_PAD: begin
                    if (can_push) begin
                        half_q <= 1'b0;
                        state  <= ST_TRL;
                    end
                end
                ST_TRL: begin
                    if (can_push) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/feb_out_stage.sv
module feb_out_stage
    import feb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  oword_t      push_word,
    output logic        can_push,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_last
);
    oword_t hold_q;
    logic   valid_q;

    assign can_push  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_data  = hold_q.data;
    assign out_last  = hold_q.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            hold_q  <= '0;
        end else if (push) begin
            valid_q <= 1'b1;
            hold_q  <= push_word;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/frag_event_builder.sv
module frag_event_builder
    import feb_pkg::*;
#(
    parameter int N_LINKS    = 8,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_LINKS-1:0]    in_valid,
    input  logic [16*N_LINKS-1:0] in_data,
    input  logic [N_LINKS-1:0]    in_last,
    output logic [N_LINKS-1:0]    in_ready,
    input  logic                  ev_valid,
    input  logic [11:0]           ev_id,
    input  logic [N_LINKS-1:0]    link_en,
    output logic                  ev_ready,
    output logic                  out_valid,
    output logic [31:0]           out_data,
    output logic                  out_last,
    input  logic                  out_ready
);
    lword_t             fifo_word [N_LINKS];
    logic [N_LINKS-1:0] fifo_avail;
    logic [N_LINKS-1:0] fifo_pop;
    logic [IDX_W-1:0]   sel_idx;
    lword_t             sel_word;
    logic               sel_avail;
    logic               sel_pop;
    logic               can_push;
    logic               push;
    oword_t             push_word;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        lword_t wr_word;
        assign wr_word.last = in_last[g];
        assign wr_word.data = in_data[16*g +: 16];

        feb_link_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
            .clk      (clk),
            .rst      (rst),
            .wr_valid (in_valid[g]),
            .wr_word  (wr_word),
            .wr_ready (in_ready[g]),
            .rd_pop   (fifo_pop[g]),
            .rd_word  (fifo_word[g]),
            .rd_avail (fifo_avail[g])
        );
    end

    always_comb begin
        sel_word  = '0;
        sel_avail = 1'b0;
        fifo_pop  = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_word    = fifo_word[i];
                sel_avail   = fifo_avail[i];
                fifo_pop[i] = sel_pop;
            end
        end
    end

    feb_merge_ctrl #(.N_LINKS(N_LINKS)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (ev_valid),
        .ev_id     (ev_id),
        .link_en   (link_en),
        .ev_ready  (ev_ready),
        .sel_idx   (sel_idx),
        .sel_avail (sel_avail),
        .sel_word  (sel_word),
        .sel_pop   (sel_pop),
        .can_push  (can_push),
        .push      (push),
        .push_word (push_word)
    );

    feb_out_stage out_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (push_word),
        .can_push  (can_push),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/feb_checker.sv
module feb_checker #(
    parameter int N_LINKS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINKS-1:0] in_valid,
    input logic [N_LINKS-1:0] in_ready,
    input logic               ev_valid,
    input logic               ev_ready,
    input logic               out_valid,
    input logic [31:0]        out_data,
    input logic               out_last,
    input logic               out_ready
);
    logic expect_hdr;

    always_ff @(posedge clk) begin
        if (rst) expect_hdr <= 1'b1;
        else if (out_valid && out_ready) expect_hdr <= out_last;
    end

    for (genvar g = 0; g < N_LINKS; g++) begin : g_rdy
        // R1: a link's ready can only fall right after a word was offered to it
        p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
            $fell(in_ready[g]) |-> $past(in_valid[g]));
    end

    p_hdr_form_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && expect_hdr) |->
            (out_data[31:28] == 4'hB && out_data[27:24] == 4'h0 && out_data[15:12] == 4'h0 && !out_last));

    p_trl_form_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (out_data[31:28] == 4'hE && out_data[26:16] == 11'h000));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_ev_single_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready) |=> !ev_ready);

endmodule

bind frag_event_builder feb_checker #(.N_LINKS(N_LINKS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/frag_event_builder_tb_top.sv
module frag_event_builder_tb_top;

    localparam int NL  = 8;
    localparam int DEP = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NL-1:0]   in_valid = '0;
    logic [16*NL-1:0] in_data = '0;
    logic [NL-1:0]   in_last = '0;
    logic [NL-1:0]   in_ready;
    logic            ev_valid = 1'b0;
    logic [11:0]     ev_id = '0;
    logic [NL-1:0]   link_en = '0;
    logic            ev_ready;
    logic            out_valid;
    logic [31:0]     out_data;
    logic            out_last;
    logic            out_ready = 1'b1;

    always #4 clk = ~clk;

    frag_event_builder #(.N_LINKS(NL), .FIFO_DEPTH(DEP)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .ev_valid(ev_valid), .ev_id(ev_id), .link_en(link_en), .ev_ready(ev_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    int          stall_bad = 0;
    bit          rnd_mode  = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [16:0] mq [NL][$];
    logic [31:0] exp_q [$];
    logic [31:0] act_q [$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    function automatic logic [15:0] fword(input int l, input logic [11:0] id, input int tag, input int k);
        if (k == 0) return {4'(l), id};
        return {4'(l), 8'(tag), 4'(k)};
    endfunction

    task automatic send_frag(input int l, input logic [11:0] id, input int tag, input int len);
        bit took;
        for (int k = 0; k < len; k++) mq[l].push_back({(k == len - 1), fword(l, id, tag, k)});
        for (int k = 0; k < len; k++) begin
            in_valid[l] = 1'b1;
            in_data[l*16 +: 16] = fword(l, id, tag, k);
            in_last[l] = (k == len - 1);
            forever begin
                took = in_ready[l];
                @(negedge clk);
                if (took) break;
            end
        end
        in_valid[l] = 1'b0;
        in_last[l]  = 1'b0;
    endtask

    function automatic void build_exp(input logic [7:0] mask, input logic [11:0] id);
        logic [15:0] w [$];
        logic [16:0] e;
        bit          err;
        bit          first;
        err = 0;
        for (int l = 0; l < NL; l++) begin
            if (mask[l]) begin
                first = 1;
                do begin
                    e = mq[l].pop_front();
                    if (first && e[11:0] != id) err = 1;
                    first = 0;
                    w.push_back(e[15:0]);
                end while (!e[16]);
            end
        end
        exp_q.delete();
        exp_q.push_back({4'hB, 4'h0, mask, 4'h0, id});
        for (int i = 0; i < w.size(); i += 2)
            exp_q.push_back({w[i], (i + 1 < w.size()) ? w[i+1] : 16'h0000});
        exp_q.push_back({4'hE, err, 11'h000, 16'(w.size())});
    endfunction

    task automatic issue(input logic [11:0] id, input logic [7:0] mask);
        bit took;
        ev_valid = 1'b1;
        ev_id    = id;
        link_en  = mask;
        forever begin
            took = ev_ready;
            @(negedge clk);
            if (took) break;
        end
        ev_valid = 1'b0;
        chk(ev_ready == 1'b0, "R8 ev_ready low while busy", 32'(ev_ready), 32'd0);
    endtask

    task automatic collect();
        bit          got_last;
        bit          prev_stall;
        logic [31:0] prev_data;
        got_last   = 0;
        prev_stall = 0;
        prev_data  = '0;
        act_q.delete();
        while (!got_last) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = rnd_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
            if (prev_stall && (!out_valid || out_data != prev_data)) stall_bad++;
            if (out_valid && out_ready) begin
                act_q.push_back(out_data);
                if (out_last) got_last = 1;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            @(negedge clk);
        end
        out_ready = 1'b1;
    endtask

    task automatic compare(input string what);
        int bad;
        bad = -1;
        checks++;
        if (act_q.size() != exp_q.size()) begin
            fails++;
            $display("FAIL %s word count actual=%0d expected=%0d", what, act_q.size(), exp_q.size());
        end else begin
            for (int i = 0; i < exp_q.size(); i++)
                if (bad < 0 && act_q[i] != exp_q[i]) bad = i;
            if (bad >= 0) begin
                fails++;
                $display("FAIL %s word %0d actual=%h expected=%h", what, bad, act_q[bad], exp_q[bad]);
            end
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] id;
        repeat (5) @(negedge clk);
        // R9: state while reset is asserted and right after it
        chk(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == '1, "R9 in_ready after reset", 32'(in_ready), 32'hFF);
        chk(ev_ready == 1'b1, "R9 ev_ready after reset", 32'(ev_ready), 32'd1);

        // R2 R3 R4 R5: every link mask, staggered lengths, alternating backpressure
        for (int e = 0; e < 256; e++) begin
            id = 12'(e * 37 + 5);
            rnd_mode = e[0];
            for (int l = 0; l < NL; l++)
                if (e[l]) send_frag(l, id, e, ((e + 3 * l) % 4) + 1);
            build_exp(8'(e), id);
            issue(id, 8'(e));
            collect();
            compare($sformatf("R2 R3 R4 R5 mask=%02h", e));
        end

        // R6: mismatched event number on link 1 still copied, error flag set
        rnd_mode = 1;
        send_frag(0, 12'h123, 17, 3);
        send_frag(1, 12'h124, 17, 2);
        build_exp(8'h03, 12'h123);
        issue(12'h123, 8'h03);
        collect();
        compare("R6 mismatch copied");
        chk(act_q.size() > 0 && act_q[act_q.size()-1][27] == 1'b1, "R6 error flag",
            (act_q.size() > 0) ? 32'(act_q[act_q.size()-1][27]) : 32'hDEAD, 32'd1);

        // R3: fragment on a disabled link stays queued for a later event
        send_frag(2, 12'h456, 33, 3);
        send_frag(0, 12'h455, 33, 2);
        build_exp(8'h01, 12'h455);
        issue(12'h455, 8'h01);
        collect();
        compare("R3 disabled link skipped");
        build_exp(8'h04, 12'h456);
        issue(12'h456, 8'h04);
        collect();
        compare("R3 held fragment taken later");

        // R1: 70-word fragment into a 64-word FIFO
        fork
            send_frag(0, 12'h789, 9, 70);
            begin
                repeat (75) @(negedge clk);
                chk(in_ready[0] == 1'b0, "R1 ready low when full", 32'(in_ready[0]), 32'd0);
                chk(in_ready[1] == 1'b1, "R1 other link unaffected", 32'(in_ready[1]), 32'd1);
                build_exp(8'h01, 12'h789);
                issue(12'h789, 8'h01);
                collect();
                compare("R1 backpressure no loss");
            end
        join
        chk(in_ready[0] == 1'b1, "R1 ready back after drain", 32'(in_ready[0]), 32'd1);

        // R7: data held during stalls across the whole run
        chk(stall_bad == 0, "R7 stable during stall", 32'(stall_bad), 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule